// File: doc/BRIEF.md
# Programmable Card Cycle Timing Sequencer

This block paces each access on a card-side bus through three phases in turn: setup, command-active and recovery. Each phase lasts a number of bus clocks held in a programmable timing set. Two complete timing sets are kept. The address window that owns an access supplies a select bit with the start request, and that bit picks the set the access runs on. The window type, memory or I/O, decides which of the two command strobes is driven.

The card can hold the command phase open through its wait input. A single-clock done pulse closes every access. Software rewrites phase lengths through a small write port. A rising edge on the power-good input restores both sets to compatibility defaults. Set 0 gets normal-wait timing and set 1 gets the same timing plus one extra command clock, which is one wait state. The power-good input is resynchronised to the bus clock before its edge is detected.

Top module: `card_cycle_timer`

## Requirements
- R1: After reset, busy, done, io_strobe and mem_strobe are low. Both timing sets hold their defaults: set 0 is setup 1, command 3, recovery 1; set 1 is setup 1, command 4, recovery 1.
- R2: A start accepted while idle yields exactly S clocks of setup (busy high, no strobe), then C clocks of command (strobe high), then R clocks of recovery (busy high, no strobe). S, C and R come from the selected set. Field code 0 is setup, 1 is command, 2 is recovery, and code 3 is discarded.
- R3: A programmed phase length of zero behaves as a length of one clock.
- R4: The set used by an access is the one named by win_set_sel (0 or 1) at the start request.
- R5: io_strobe is high only during the command phase of an access started with win_is_io=1. mem_strobe is high only during the command phase of one started with win_is_io=0. The two strobes are never high together.
- R6: While card_wait is high at the end of the programmed command count, the command phase continues. It ends on the first clock edge that finds card_wait low, so the command phase lasts max(C, W+1) clocks when wait covers the first W command clocks.
- R7: done is high for exactly one clock, in the clock right after the last recovery clock, with busy still high. In the clock after done, busy is low.
- R8: A start request arriving while busy is high is discarded and starts no new access.
- R9: A register write during an access does not change that access's phase lengths. It takes effect from the next access.
- R10: A rising edge of pwr_good reloads both sets with the defaults of R1, overriding any earlier writes. A write in the same clock as the reload is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Power-good level; its rising edge reloads defaults |
| start | input | 1 | Access request, sampled while idle |
| win_is_io | input | 1 | 1 = I/O window access, 0 = memory window access |
| win_set_sel | input | 1 | Timing set chosen by the requesting window |
| card_wait | input | 1 | Card wait request, extends the command phase |
| reg_wr_en | input | 1 | Timing register write strobe |
| reg_wr_set | input | 1 | Set addressed by the write |
| reg_wr_field | input | 2 | 0 setup, 1 command, 2 recovery, 3 none |
| reg_wr_data | input | 8 | Phase length in bus clocks |
| io_strobe | output | 1 | I/O command strobe |
| mem_strobe | output | 1 | Memory command strobe |
| busy | output | 1 | Access in progress, through the done clock |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
Every cycle, the assertions check that the strobes are mutually exclusive and appear only while busy. They also check that done lasts one clock and is followed by idle, that an idle start makes the block busy, and that a held wait keeps the strobe up. The phase lengths can only be shown by the bench scenarios, which count clocks per phase against programmed values. The same holds for zero-as-one, set selection, the wait-stretched command length, discarded starts, writes deferred to the next access, and the power-good reload.

// File: rtl/cct_pkg.sv
// Package: shared types and helpers for the card cycle timing sequencer.
// Assumes phase lengths are unsigned clock counts of CCT_CNT_W bits.
package cct_pkg;
    localparam int CCT_CNT_W = 8;

    typedef logic [CCT_CNT_W-1:0] cct_len_t;

    // One timing set: a length for each of the three phases.
    typedef struct packed {
        cct_len_t setup_len;
        cct_len_t cmd_len;
        cct_len_t rec_len;
    } cct_timing_t;

    typedef enum logic [1:0] {
        FLD_SETUP = 2'd0,
        FLD_CMD   = 2'd1,
        FLD_REC   = 2'd2,
        FLD_NONE  = 2'd3
    } cct_field_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_CMD   = 3'd2,
        PH_REC   = 3'd3,
        PH_DONE  = 3'd4
    } cct_phase_t;

    // Map a zero length onto one clock.
    function automatic cct_len_t cct_norm(input cct_len_t v);
        return (v == '0) ? cct_len_t'(1) : v;
    endfunction

    // Default set for index idx: each higher set adds step command clocks.
    function automatic cct_timing_t cct_default(input int idx, input int s,
                                                input int c, input int r,
                                                input int step);
        cct_timing_t t;
        t.setup_len = cct_len_t'(s);
        t.cmd_len   = cct_len_t'(c + idx * step);
        t.rec_len   = cct_len_t'(r);
        return t;
    endfunction
endpackage

// File: rtl/cct_pg_edge.sv
// Module: resynchronises the power-good level to the bus clock and emits a
// one-clock pulse on its rising edge. Assumes pwr_good is asynchronous.
module cct_pg_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_in,
    output logic pg_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pg_in};
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pg_rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/cct_timing_regs.sv
// Module: holds NUM_SETS timing sets, written one field at a time and
// reloaded with compatibility defaults on load_dflt. A reload takes priority
// over a write in the same clock. Writes to an absent set or field are dropped.
module cct_timing_regs
    import cct_pkg::*;
#(
    parameter int NUM_SETS  = 2,
    parameter int DEF_SETUP = 1,
    parameter int DEF_CMD   = 3,
    parameter int DEF_REC   = 1,
    parameter int WAIT_STEP = 1,
    localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_dflt,
    input  logic                 wr_en,
    input  logic [SET_W-1:0]     wr_set,
    input  logic [1:0]           wr_field,
    input  cct_len_t             wr_data,
    output cct_timing_t          sets_q [NUM_SETS]
);
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        localparam cct_timing_t DFLT =
            cct_default(g, DEF_SETUP, DEF_CMD, DEF_REC, WAIT_STEP);
        logic hit;
        assign hit = wr_en && (int'(wr_set) == g);

        // Hold one timing set: defaults on reset or reload, else field writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sets_q[g] <= DFLT;
            end else if (load_dflt) begin
                sets_q[g] <= DFLT;
            end else if (hit) begin
                case (cct_field_t'(wr_field))
                    FLD_SETUP: sets_q[g].setup_len <= wr_data;
                    FLD_CMD:   sets_q[g].cmd_len   <= wr_data;
                    FLD_REC:   sets_q[g].rec_len   <= wr_data;
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cct_phase_fsm.sv
// Module: runs one access through setup, command and recovery, then a done
// clock. Phase lengths and the window type are captured at the start request,
// so later register writes cannot disturb a running access. Starts are only
// sampled while idle.
module cct_phase_fsm
    import cct_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        win_is_io,
    input  cct_timing_t sel_timing,
    input  logic        card_wait,
    output logic        io_strobe,
    output logic        mem_strobe,
    output logic        busy,
    output logic        done
);
    cct_phase_t phase_q;
    cct_len_t   cnt_q;
    cct_len_t   cmd_len_q;
    cct_len_t   rec_len_q;
    logic       is_io_q;
    logic       last_clk;

    assign last_clk = (cnt_q == cct_len_t'(1));

    // Advance the phase and its clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= cct_norm(sel_timing.setup_len);
                    end
                end
                PH_SETUP: begin
                    if (last_clk) begin
                        phase_q <= PH_CMD;
                        cnt_q   <= cmd_len_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_CMD: begin
                    if (last_clk) begin
                        if (!card_wait) begin
                            phase_q <= PH_REC;
                            cnt_q   <= rec_len_q;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_REC: begin
                    if (last_clk) begin
                        phase_q <= PH_DONE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // Capture the later phase lengths and window type at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_len_q <= cct_len_t'(1);
            rec_len_q <= cct_len_t'(1);
            is_io_q   <= 1'b0;
        end else if (phase_q == PH_IDLE && start) begin
            cmd_len_q <= cct_norm(sel_timing.cmd_len);
            rec_len_q <= cct_norm(sel_timing.rec_len);
            is_io_q   <= win_is_io;
        end
    end

    assign io_strobe  = (phase_q == PH_CMD) &&  is_io_q;
    assign mem_strobe = (phase_q == PH_CMD) && !is_io_q;
    assign busy       = (phase_q != PH_IDLE);
    assign done       = (phase_q == PH_DONE);
endmodule

// File: rtl/card_cycle_timer.sv
// Module: top of the card cycle timing sequencer. Detects power-good rise,
// holds the timing sets, picks the set named by the requesting window and
// runs the phase sequencer. Assumes all inputs except pwr_good are
// synchronous to clk.
module card_cycle_timer
    import cct_pkg::*;
#(
    parameter int NUM_SETS    = 2,
    parameter int DEF_SETUP   = 1,
    parameter int DEF_CMD     = 3,
    parameter int DEF_REC     = 1,
    parameter int WAIT_STEP   = 1,
    parameter int SYNC_STAGES = 2,
    localparam int SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             start,
    input  logic             win_is_io,
    input  logic [SET_W-1:0] win_set_sel,
    input  logic             card_wait,
    input  logic             reg_wr_en,
    input  logic [SET_W-1:0] reg_wr_set,
    input  logic [1:0]       reg_wr_field,
    input  logic [7:0]       reg_wr_data,
    output logic             io_strobe,
    output logic             mem_strobe,
    output logic             busy,
    output logic             done
);
    logic        pg_rise;
    cct_timing_t sets_q [NUM_SETS];
    cct_timing_t sel_timing;

    cct_pg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pg (
        .clk     (clk),
        .rst_n   (rst_n),
        .pg_in   (pwr_good),
        .pg_rise (pg_rise)
    );

    cct_timing_regs #(
        .NUM_SETS  (NUM_SETS),
        .DEF_SETUP (DEF_SETUP),
        .DEF_CMD   (DEF_CMD),
        .DEF_REC   (DEF_REC),
        .WAIT_STEP (WAIT_STEP)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_dflt (pg_rise),
        .wr_en     (reg_wr_en),
        .wr_set    (reg_wr_set),
        .wr_field  (reg_wr_field),
        .wr_data   (cct_len_t'(reg_wr_data)),
        .sets_q    (sets_q)
    );

    // Select the timing set named by the requesting window.
    always_comb begin
        sel_timing = sets_q[0];
        for (int i = 0; i < NUM_SETS; i++) begin
            if (int'(win_set_sel) == i) sel_timing = sets_q[i];
        end
    end

    cct_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .win_is_io  (win_is_io),
        .sel_timing (sel_timing),
        .card_wait  (card_wait),
        .io_strobe  (io_strobe),
        .mem_strobe (mem_strobe),
        .busy       (busy),
        .done       (done)
    );
endmodule

// File: rtl/cct_checker.sv
// Module: protocol checks on the sequencer's ports, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module cct_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic card_wait,
    input logic io_strobe,
    input logic mem_strobe,
    input logic busy,
    input logic done
);
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_strobe && mem_strobe)); // R5
    AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe || mem_strobe) |-> busy && !done); // R5
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R7
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R7
    AST_IDLE_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy && !done); // R2
    AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_strobe || mem_strobe) && card_wait) |=> (io_strobe || mem_strobe)); // R6
    AST_STROBE_TYPE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && $past(io_strobe || mem_strobe)) |-> $past(io_strobe)); // R5
endmodule

bind card_cycle_timer cct_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .card_wait  (card_wait),
    .io_strobe  (io_strobe),
    .mem_strobe (mem_strobe),
    .busy       (busy),
    .done       (done)
);

// File: tb/card_cycle_timer_tb.sv
// Bench: directed scenarios for the card cycle timing sequencer.
module card_cycle_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       start = 1'b0;
    logic       win_is_io = 1'b0;
    logic       win_set_sel = 1'b0;
    logic       card_wait = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_wr_set = 1'b0;
    logic [1:0] reg_wr_field = 2'd0;
    logic [7:0] reg_wr_data = 8'd0;
    logic       io_strobe, mem_strobe, busy, done;

    int n_checks = 0;
    int n_fail   = 0;

    card_cycle_timer u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .start(start),
        .win_is_io(win_is_io), .win_set_sel(win_set_sel), .card_wait(card_wait),
        .reg_wr_en(reg_wr_en), .reg_wr_set(reg_wr_set),
        .reg_wr_field(reg_wr_field), .reg_wr_data(reg_wr_data),
        .io_strobe(io_strobe), .mem_strobe(mem_strobe), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wr(input bit set, input int field, input int data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_set = set;
        reg_wr_field = 2'(field); reg_wr_data = 8'(data);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // One access; counts clocks per phase and compares against expectations.
    task automatic access(input string tag, input bit sel, input bit io,
                          input int es, input int ec, input int er,
                          input int wait_w, input bit poke_start,
                          input bit poke_write, input int poke_val);
        int s_n = 0, c_n = 0, r_n = 0, bad_strobe = 0, guard = 0;
        bit seen_done = 0, rel_start = 0, rel_wr = 0, poked_w = 0;
        @(negedge clk);
        win_set_sel = sel; win_is_io = io; start = 1'b1;
        card_wait = (wait_w > 0);
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && guard < 1000) begin
            if (rel_start) begin start = 1'b0; rel_start = 0; end
            if (rel_wr) begin reg_wr_en = 1'b0; rel_wr = 0; end
            if (done) seen_done = 1;
            else if (io_strobe || mem_strobe) begin
                c_n++;
                if (io ? mem_strobe : io_strobe) bad_strobe++;
                if (wait_w > 0 && c_n == wait_w + 1) card_wait = 1'b0;
                if (poke_start && c_n == 1) begin start = 1'b1; rel_start = 1; end
            end else if (busy && c_n == 0) begin
                s_n++;
                if (poke_write && !poked_w) begin
                    reg_wr_en = 1'b1; reg_wr_set = sel; reg_wr_field = 2'd1;
                    reg_wr_data = 8'(poke_val); rel_wr = 1; poked_w = 1;
                end
            end else if (busy) r_n++;
            guard++;
            if (!seen_done) @(negedge clk);
        end
        card_wait = 1'b0;
        chk(seen_done, {tag, " R7 done seen"}, int'(seen_done), 1);
        chk(s_n == es, {tag, " R2 setup clocks"}, s_n, es);
        chk(c_n == ec, {tag, " R2 command clocks"}, c_n, ec);
        chk(r_n == er, {tag, " R2 recovery clocks"}, r_n, er);
        chk(bad_strobe == 0, {tag, " R5 wrong strobe"}, bad_strobe, 0);
        chk(busy == 1'b1, {tag, " R7 busy during done"}, int'(busy), 1);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R7 done one clock"}, int'(done), 0);
        chk(busy == 1'b0, {tag, " R7 idle after done"}, int'(busy), 0);
        if (poke_start) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(busy == 1'b0, {tag, " R8 busy start ignored"}, int'(busy), 0);
            end
        end
    endtask

    task automatic t_reset();
        chk(busy == 0, "R1 reset busy", int'(busy), 0);
        chk(done == 0, "R1 reset done", int'(done), 0);
        chk(io_strobe == 0 && mem_strobe == 0, "R1 reset strobes",
            int'(io_strobe) + int'(mem_strobe), 0);
    endtask

    task automatic t_defaults();
        access("R1 set0 mem default", 1'b0, 1'b0, 1, 3, 1, 0, 0, 0, 0);
        access("R1 set1 io default", 1'b1, 1'b1, 1, 4, 1, 0, 0, 0, 0);
    endtask

    task automatic t_programmed();
        wr(1'b0, 0, 2); wr(1'b0, 1, 5); wr(1'b0, 2, 3);
        wr(1'b1, 0, 4); wr(1'b1, 1, 2); wr(1'b1, 2, 6);
        wr(1'b0, 3, 9);
        access("R4 set0 io", 1'b0, 1'b1, 2, 5, 3, 0, 0, 0, 0);
        access("R4 set1 mem", 1'b1, 1'b0, 4, 2, 6, 0, 0, 0, 0);
    endtask

    task automatic t_zero();
        wr(1'b0, 0, 0); wr(1'b0, 1, 0); wr(1'b0, 2, 0);
        access("R3 zero lengths", 1'b0, 1'b0, 1, 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_wait();
        access("R6 wait stretch", 1'b1, 1'b1, 4, 6, 6, 5, 0, 0, 0);
        access("R6 wait within count", 1'b1, 1'b0, 4, 2, 6, 1, 0, 0, 0);
    endtask

    task automatic t_busy_start();
        access("R8 start while busy", 1'b1, 1'b0, 4, 2, 6, 0, 1, 0, 0);
    endtask

    task automatic t_midwrite();
        access("R9 write during access", 1'b1, 1'b1, 4, 2, 6, 0, 0, 1, 7);
        access("R9 write applied next", 1'b1, 1'b1, 4, 7, 6, 0, 0, 0, 0);
    endtask

    task automatic t_pg();
        @(negedge clk); pwr_good = 1'b0;
        repeat (4) @(negedge clk);
        pwr_good = 1'b1;
        repeat (6) @(negedge clk);
        access("R10 set0 reload", 1'b0, 1'b0, 1, 3, 1, 0, 0, 0, 0);
        access("R10 set1 reload", 1'b1, 1'b1, 1, 4, 1, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        pwr_good = 1'b1;
        repeat (6) @(negedge clk);
        t_defaults();
        t_programmed();
        t_wait();
        t_busy_start();
        t_midwrite();
        t_zero();
        t_pg();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule